// File: doc/BRIEF.md
# Baseband Serial Transmit Port Controller

This block sits on the MAC side of a serial transmit link to a wireless baseband processor. A packet is started by a one-cycle `start` pulse that carries the byte count and a two-bit rate code. The block raises `tx_en` towards the baseband and waits for the baseband's ready line. It then puts packet bytes on `tx_data` one bit per baseband bit clock, least significant bit first. Bytes arrive on a valid/ready byte stream.

The baseband bit clock and ready line are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the bit clock also goes through a rising-edge detector. After the last bit has been sampled, `tx_en` is held for a rate-dependent number of system cycles and then dropped. This keeps the baseband's final clock phase intact and stays inside that rate's deadline. Once ready falls, the block keeps `tx_en` low for a minimum idle gap, pulses `done`, and only then accepts another start.

Back-pressure on the byte stream: `s_ready` is high only while a packet is active, its one-byte shift register is empty and bytes of the packet remain to be fetched. A byte moves on a system clock edge where `s_valid` and `s_ready` are both high. The source may hold `s_valid` high at any time. If the source falls behind, the packet is aborted and a sticky flag is set.

Top module: `bbtx_ctrl`

## Requirements
- R1: Out of reset, `tx_en`, `tx_data`, `s_ready`, `busy`, `done` and `underrun_err` are all 0.
- R2: A `start` pulse with nonzero `pkt_len` seen while idle sets `tx_en` and `busy` on that clock edge. The rate code is latched at that edge, so later changes of `rate_sel` have no effect on the packet. Rate codes: 0 = 1 Mbps, 1 = 2 Mbps, 2 = 5.5 Mbps, 3 = 11 Mbps.
- R3: `s_ready` is high only while a packet is active, the shift register is empty and fewer than `pkt_len` bytes have been taken. It is 0 when idle.
- R4: Bytes go out least significant bit first. The bit sampled at each baseband clock rising edge is bit (k mod 8) of byte k/8, where k counts edges from 0. `tx_data` advances on the third system clock edge after the bit-clock rise.
- R5: Bit-clock rising edges before the synchronised ready line is high do not shift data.
- R6: After the bit-clock rise that samples the last bit, `tx_en` falls on system edge 3 + D, where D is the drop delay of the latched rate. The defaults are D = 45, 18, 5 and 0, for falls after 48, 21, 8 and 3 cycles.
- R7: A bit-clock rise while the shift register is empty and bits remain is an underrun. It sets `underrun_err`, which stays set until reset, and `tx_en` falls 3 system edges after that rise.
- R8: After `tx_en` is low and the synchronised ready line has fallen, `GAP_CYC` further cycles pass. Then `done` pulses for exactly one cycle and `busy` clears. The time from the `tx_en` fall to `done` is at least `GAP_CYC` cycles.
- R9: A `start` while busy, or with `pkt_len` equal to 0, is ignored. `tx_en` stays low and no packet is queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Packet start pulse |
| pkt_len | input | LEN_W | Packet length in bytes |
| rate_sel | input | 2 | Rate code (0..3) |
| s_valid | input | 1 | Byte stream valid |
| s_ready | output | 1 | Byte stream ready |
| s_data | input | BYTE_W | Byte stream data |
| bb_clk | input | 1 | Baseband bit clock (asynchronous) |
| bb_rdy | input | 1 | Baseband ready (asynchronous) |
| tx_en | output | 1 | Transmit enable to baseband |
| tx_data | output | 1 | Serial data to baseband |
| busy | output | 1 | Packet in progress or idle gap running |
| done | output | 1 | One-cycle end-of-packet pulse |
| underrun_err | output | 1 | Sticky byte underrun flag |

## Verification
Packets of one to four bytes are run at every rate code, each with its own byte pattern. Every sampled bit is compared, so a reversed bit order or a lost byte boundary shows up. The measured drop latency separates the four rate deadlines, and it also shows whether the rate was latched, because `rate_sel` is changed right after each start. Each packet begins with a bit-clock pulse before ready, to catch early shifting. Directed runs cover reset, a zero-length start, a start during the idle gap, and a stalled byte source that must abort after the first byte.

// File: rtl/bbtx_pkg.sv
package bbtx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_RDY, ST_SHIFT, ST_DRAIN, ST_WAIT_END, ST_GAP
  } bbtx_state_t;

  typedef enum logic [1:0] {
    RATE_1M = 2'd0, RATE_2M = 2'd1, RATE_5M5 = 2'd2, RATE_11M = 2'd3
  } bbtx_rate_t;

  function automatic int bbtx_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bbtx_sync.sv
module bbtx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain  <= '0;
      prev_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], async_in};
      prev_q <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/bbtx_shifter.sv
module bbtx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              shift,
  input  logic              flush,
  output logic              bit_out,
  output logic              empty
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (flush) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load) begin
      sreg <= din;
      cnt  <= CNT_W'(BYTE_W);
    end else if (shift) begin
      sreg <= sreg >> 1;
      cnt  <= cnt - 1'b1;
    end
  end

  assign bit_out = sreg[0];
  assign empty   = (cnt == '0);

  assert_load_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> empty);
  assert_shift_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !flush) |-> !empty);
endmodule

// File: rtl/bbtx_timer.sv
module bbtx_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= value;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !zero) |=> !$stable(cnt));
endmodule

// File: rtl/bbtx_ctrl.sv
module bbtx_ctrl
  import bbtx_pkg::*;
#(
  parameter int LEN_W    = 12,
  parameter int BYTE_W   = 8,
  parameter int GAP_CYC  = 112,
  parameter int DROP_1M  = 45,
  parameter int DROP_2M  = 18,
  parameter int DROP_5M5 = 5,
  parameter int DROP_11M = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic [1:0]        rate_sel,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              bb_clk,
  input  logic              bb_rdy,
  output logic              tx_en,
  output logic              tx_data,
  output logic              busy,
  output logic              done,
  output logic              underrun_err
);
  localparam int TMR_MAX = bbtx_max(bbtx_max(GAP_CYC, DROP_1M),
                                    bbtx_max(bbtx_max(DROP_2M, DROP_5M5), DROP_11M));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int BITS_W  = LEN_W + $clog2(BYTE_W) + 1;

  bbtx_state_t       state;
  bbtx_rate_t        rate_q;
  logic [LEN_W-1:0]  fetch_left;
  logic [BITS_W-1:0] bits_left;

  logic clk_rise, clk_lvl, rdy_lvl, rdy_rise;
  logic sh_empty, sh_load, sh_shift, sh_flush;
  logic tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val, drop_val;
  logic edge_act, abort, last_bit;

  bbtx_sync #(.STAGES(2)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bb_clk), .level(clk_lvl), .rise(clk_rise));
  bbtx_sync #(.STAGES(2)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bb_rdy), .level(rdy_lvl), .rise(rdy_rise));

  always_comb begin
    case (rate_q)
      RATE_1M:  drop_val = TMR_W'(DROP_1M);
      RATE_2M:  drop_val = TMR_W'(DROP_2M);
      RATE_5M5: drop_val = TMR_W'(DROP_5M5);
      default:  drop_val = TMR_W'(DROP_11M);
    endcase
  end

  assign edge_act = (state == ST_SHIFT) && clk_rise;
  assign abort    = edge_act && sh_empty;
  assign last_bit = edge_act && !sh_empty && (bits_left == BITS_W'(1));
  assign s_ready  = ((state == ST_WAIT_RDY) || (state == ST_SHIFT)) && sh_empty &&
                    (fetch_left != '0) && !abort;
  assign sh_load  = s_valid && s_ready;
  assign sh_shift = edge_act && !sh_empty;
  assign sh_flush = abort;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (last_bit && drop_val != '0) begin
      tmr_load = 1'b1;
      tmr_val  = drop_val - 1'b1;
    end else if (state == ST_WAIT_END && !rdy_lvl) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(GAP_CYC - 1);
    end
  end

  bbtx_shifter #(.BYTE_W(BYTE_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .din(s_data), .shift(sh_shift),
    .flush(sh_flush), .bit_out(tx_data), .empty(sh_empty));

  bbtx_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_val), .zero(tmr_zero));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      rate_q       <= RATE_1M;
      fetch_left   <= '0;
      bits_left    <= '0;
      tx_en        <= 1'b0;
      done         <= 1'b0;
      underrun_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sh_load) fetch_left <= fetch_left - 1'b1;
      case (state)
        ST_IDLE: if (start && pkt_len != '0) begin
          tx_en      <= 1'b1;
          rate_q     <= bbtx_rate_t'(rate_sel);
          fetch_left <= pkt_len;
          bits_left  <= BITS_W'(int'(pkt_len) * BYTE_W);
          state      <= ST_WAIT_RDY;
        end
        ST_WAIT_RDY: if (rdy_lvl) state <= ST_SHIFT;
        ST_SHIFT: if (abort) begin
          underrun_err <= 1'b1;
          tx_en        <= 1'b0;
          state        <= ST_WAIT_END;
        end else if (sh_shift) begin
          bits_left <= bits_left - 1'b1;
          if (last_bit) begin
            if (drop_val == '0) begin
              tx_en <= 1'b0;
              state <= ST_WAIT_END;
            end else begin
              state <= ST_DRAIN;
            end
          end
        end
        ST_DRAIN: if (tmr_zero) begin
          tx_en <= 1'b0;
          state <= ST_WAIT_END;
        end
        ST_WAIT_END: if (!rdy_lvl) state <= ST_GAP;
        ST_GAP: if (tmr_zero) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  assert_txen_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(start) && $past(pkt_len != '0));
  assert_idle_no_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !s_ready);
  assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !tmr_zero) |=> tx_en);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_err |=> underrun_err);
  assert_done_txen_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_en && !busy);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tx_en) |=> !$rose(tx_en));
endmodule

// File: tb/test_bbtx_ctrl.sv
module test_bbtx_ctrl;
  localparam int LEN_W = 12;
  localparam int GAP   = 112;
  localparam int NV    = 5;
  localparam int VEC_RATE [NV] = '{0, 1, 2, 3, 1};
  localparam int VEC_LEN  [NV] = '{1, 2, 3, 2, 4};
  localparam int VEC_SEED [NV] = '{8'hA5, 8'h3C, 8'h01, 8'hF0, 8'h5E};
  localparam int VEC_LAT  [NV] = '{48, 21, 8, 3, 21};
  localparam int HALF [4] = '{30, 14, 8, 6};

  logic clk = 0, rst_n = 0, start = 0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [1:0] rate_sel = '0;
  logic s_valid = 0, s_ready;
  logic [7:0] s_data = '0;
  logic bb_clk = 0, bb_rdy = 0;
  logic tx_en, tx_data, busy, done, underrun_err;

  int checks = 0, errors = 0, cyc = 0;
  int edge_cyc, fall_cyc, done_cyc;
  bit finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bbtx_ctrl #(.LEN_W(LEN_W), .GAP_CYC(GAP)) i_bbtx_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .pkt_len(pkt_len), .rate_sel(rate_sel),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .bb_clk(bb_clk),
    .bb_rdy(bb_rdy), .tx_en(tx_en), .tx_data(tx_data), .busy(busy), .done(done),
    .underrun_err(underrun_err));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int seed, input int i);
    return 8'((seed + i * 37) & 255);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // stall < 0: source never stalls; poke: start attempted during the gap
  task automatic run_pkt(input int rate, input int len, input int seed, input int stall,
                         input int exp_lat, input bit poke);
    int nbits = (stall >= 0) ? stall * 8 : len * 8;
    int refe  = (stall >= 0) ? stall * 8 + 1 : len * 8;
    int bad   = 0;
    @(negedge clk);
    start = 1; pkt_len = LEN_W'(len); rate_sel = 2'(rate);
    @(negedge clk);
    start = 0; rate_sel = 2'(3 - rate);
    chk(tx_en && busy, "R2 tx_en/busy after start", int'(tx_en), 1);
    fork
      begin : feeder
        for (int i = 0; i < len; i++) begin
          if (i == stall) break;
          s_valid = 1; s_data = byte_of(seed, i);
          while (1) begin
            if (s_ready) begin @(negedge clk); break; end
            @(negedge clk);
          end
        end
        s_valid = 0;
      end
      begin : bbmodel
        int k = 0;
        repeat (4) @(negedge clk);
        bb_clk = 1; repeat (4) @(negedge clk); bb_clk = 0;
        repeat (4) @(negedge clk);
        bb_rdy = 1;
        repeat (13) @(negedge clk);
        while (tx_en) begin
          if (k < nbits) begin
            logic [7:0] b = byte_of(seed, k / 8);
            if (tx_data !== b[k % 8]) bad++;
            checks++;
          end
          bb_clk = 1; k++;
          if (k == refe) edge_cyc = cyc;
          repeat (HALF[rate]) @(negedge clk);
          bb_clk = 0;
          repeat (HALF[rate]) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        bb_rdy = 0;
      end
      begin : monitor
        int t = 0;
        while (tx_en) @(negedge clk);
        fall_cyc = cyc;
        if (poke) begin
          repeat (5) @(negedge clk);
          start = 1; pkt_len = 2; @(negedge clk); start = 0;
        end
        while (!done && t < 3000) begin
          if (tx_en) bad += 1000;
          @(negedge clk); t++;
        end
        done_cyc = cyc;
        chk(done === 1'b1, "R8 done pulse seen", int'(done), 1);
        @(negedge clk);
        chk(!done && !busy, "R8 done single cycle, busy clear", int'(done), 0);
      end
    join
    errors += (bad % 1000 != 0) ? 1 : 0;
    if (bad % 1000 != 0)
      $display("FAIL R4/R5 bit order: actual %0d mismatching bits expected 0", bad % 1000);
    chk(bad < 1000, "R9 tx_en stayed low until done", bad / 1000, 0);
    chk(fall_cyc - edge_cyc == exp_lat, (stall >= 0) ? "R7 abort latency" : "R6 drop latency",
        fall_cyc - edge_cyc, exp_lat);
    chk(done_cyc - fall_cyc >= GAP, "R8 idle gap", done_cyc - fall_cyc, GAP);
    chk(!s_ready, "R3 ready low when idle", int'(s_ready), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({tx_en, tx_data, s_ready, busy, done, underrun_err} == 6'b0, "R1 reset outputs",
        int'({tx_en, tx_data, s_ready, busy, done, underrun_err}), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!tx_en && !busy, "R1 idle after reset", int'(busy), 0);

    // vector table walk
    for (int v = 0; v < NV; v++)
      run_pkt(VEC_RATE[v], VEC_LEN[v], VEC_SEED[v], -1, VEC_LAT[v], v == 1);
    chk(!underrun_err, "R7 no error on clean packets", int'(underrun_err), 0);

    // R9 zero length start ignored
    @(negedge clk); start = 1; pkt_len = 0; @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    chk(!tx_en && !busy, "R9 zero-length start ignored", int'(tx_en), 0);

    // R9 start during gap (poke) left nothing pending
    chk(!s_ready && !tx_en, "R9 no queued packet", int'(tx_en), 0);

    // R7 underrun: source stalls after the first byte
    run_pkt(2, 3, 8'h77, 1, 3, 0);
    chk(underrun_err, "R7 underrun flag set", int'(underrun_err), 1);
    repeat (20) @(negedge clk);
    chk(underrun_err, "R7 underrun flag sticky", int'(underrun_err), 1);

    // a further clean packet after abort still runs
    run_pkt(3, 1, 8'h81, -1, 3, 0);
    chk(underrun_err, "R7 flag kept until reset", int'(underrun_err), 1);
    finish_run();
  end
endmodule